// File: doc/BRIEF.md
# Condition Code Flag Unit

This block keeps a four-bit condition code register (negative, zero, positive, overflow) and answers branch questions against it. An execute stage hands it a result word and an overflow bit along with a per-instruction request to record flags. The register changes only on cycles where that request is high. Instructions that do not ask leave the stored flags alone, so the compare that feeds a branch can be scheduled many instructions ahead of it.

A branch presents a three-bit condition select. The unit returns a combinational taken/not-taken answer that depends only on the stored flags and that select. When a flag update and a branch evaluation fall in the same cycle, the branch sees the flags as they stood before the update. Parameters set the data width and choose how the zero detector is built.

Top module: `ccu_flag_unit`

## Requirements
- R1: While reset is asserted, and after it is released, all four flags are 0 until the first update. Selects 0 to 3 then give not-taken and selects 4 to 7 give taken.
- R2: On an update, the negative flag takes the most significant bit of the result.
- R3: On an update, the zero flag is 1 exactly when every result bit is 0.
- R4: On an update, the positive flag is 1 exactly when the result is non-zero and its top bit is 0. After any update exactly one of negative, zero and positive is 1.
- R5: On every update, the overflow flag is loaded from the overflow input, including loading a 0.
- R6: When the set-flags input is low, the result and overflow inputs have no effect and all four flags keep their values.
- R7: Condition select encoding: 0 = negative, 1 = zero, 2 = positive, 3 = overflow. Values 4, 5, 6 and 7 give the inverse of 0, 1, 2 and 3 respectively. The taken output is the selected term.
- R8: The taken output in a cycle with an update reflects the flags held before that update. The new flags appear after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_i | input | DATA_W | Result word of the current instruction |
| ovf_i | input | 1 | Overflow indication for the result |
| setfl_i | input | 1 | High when this instruction records flags |
| csel_i | input | 3 | Branch condition select |
| taken_o | output | 1 | Branch decision from the stored flags |

## Verification
Results are chosen to fall into each sign class: a negative value with only the top bit and the lowest bit set, zero, and a small positive value. After each one, all eight selects are swept, which shows whether negative, zero and positive are told apart and whether the inverted selects mirror the direct ones. Updates whose overflow input differs from the stored overflow flag, in both directions, show that overflow is loaded every time rather than only set. Cycles with set-flags low carry results and overflow that would change every flag, which exposes any leak of the hold path. A branch evaluated in an update cycle against a flag that the update is about to change separates the pre-update value from the post-update value. A long random stream then compares taken against the model on every cycle.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

   // Stored flag set; the field order is used by the condition select decode.
   typedef struct packed {
      logic neg;
      logic zer;
      logic pos;
      logic ovf;
   } ccu_flags_t;

   localparam int unsigned CSEL_W = 3;

   typedef enum logic [CSEL_W-1:0] {
      CC_NEG  = 3'd0,
      CC_ZER  = 3'd1,
      CC_POS  = 3'd2,
      CC_OVF  = 3'd3,
      CC_NNEG = 3'd4,
      CC_NZER = 3'd5,
      CC_NPOS = 3'd6,
      CC_NOVF = 3'd7
   } ccu_cond_e;

endpackage

// File: rtl/ccu_zero_det.sv
module ccu_zero_det #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          USE_TREE  = 1'b1,
   parameter int unsigned CHUNK_W   = 8
) (
   input  logic [DATA_W-1:0] word_i,
   output logic              is_zero_o
);
   localparam int unsigned NCHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
   localparam int unsigned PAD_W  = NCHUNK * CHUNK_W;

   generate
      if (CHUNK_W < 1) begin : g_bad_chunk
         $error("ccu_zero_det: CHUNK_W must be at least 1");
      end

      if (USE_TREE) begin : g_tree
         logic [PAD_W-1:0]  padded;
         logic [NCHUNK-1:0] chunk_any;

         always_comb begin
            padded = '0;
            padded[DATA_W-1:0] = word_i;
         end

         for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
            assign chunk_any[c] = |padded[c*CHUNK_W +: CHUNK_W];
         end

         assign is_zero_o = ~|chunk_any;
      end else begin : g_flat
         assign is_zero_o = ~|word_i;
      end
   endgenerate

endmodule

// File: rtl/ccu_flag_next.sv
module ccu_flag_next
   import ccu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic       sign_i,
   input  logic       zero_i,
   input  logic       ovf_i,
   output ccu_flags_t next_o
);
   always_comb begin
      next_o.neg = sign_i;
      next_o.zer = zero_i;
      next_o.pos = ~sign_i & ~zero_i;
      next_o.ovf = ovf_i;
   end

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("ccu_flag_next: DATA_W must be at least 2");
      end
   endgenerate

endmodule

// File: rtl/ccu_flag_reg.sv
module ccu_flag_reg
   import ccu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  ccu_flags_t next_i,
   output ccu_flags_t flags_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_o <= '0;
      end else if (load_i) begin
         flags_o <= next_i;
      end
   end

endmodule

// File: rtl/ccu_cond_mux.sv
module ccu_cond_mux
   import ccu_pkg::*;
(
   input  ccu_flags_t        flags_i,
   input  logic [CSEL_W-1:0] csel_i,
   output logic              taken_o
);
   logic base;

   always_comb begin
      unique case (csel_i[1:0])
         2'd0:    base = flags_i.neg;
         2'd1:    base = flags_i.zer;
         2'd2:    base = flags_i.pos;
         default: base = flags_i.ovf;
      endcase
      taken_o = base ^ csel_i[CSEL_W-1];
   end

endmodule

// File: rtl/ccu_flag_unit.sv
module ccu_flag_unit
   import ccu_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_TREE = 1'b1,
   parameter int unsigned ZCHUNK_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] res_i,
   input  logic              ovf_i,
   input  logic              setfl_i,
   input  logic [2:0]        csel_i,
   output logic              taken_o
);
   localparam int unsigned SIGN_BIT = DATA_W - 1;

   logic       res_zero;
   ccu_flags_t flags_next;
   ccu_flags_t flags_q;

   ccu_zero_det #(
      .DATA_W   (DATA_W),
      .USE_TREE (ZERO_TREE),
      .CHUNK_W  (ZCHUNK_W)
   ) u_zdet (
      .word_i    (res_i),
      .is_zero_o (res_zero)
   );

   ccu_flag_next #(
      .DATA_W (DATA_W)
   ) u_next (
      .sign_i (res_i[SIGN_BIT]),
      .zero_i (res_zero),
      .ovf_i  (ovf_i),
      .next_o (flags_next)
   );

   ccu_flag_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (setfl_i),
      .next_i  (flags_next),
      .flags_o (flags_q)
   );

   ccu_cond_mux u_mux (
      .flags_i (flags_q),
      .csel_i  (csel_i),
      .taken_o (taken_o)
   );

endmodule

// File: rtl/ccu_flag_unit_chk.sv
module ccu_flag_unit_chk
   import ccu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] res_i,
   input logic              ovf_i,
   input logic              setfl_i,
   input logic [2:0]        csel_i,
   input logic              taken_o,
   input ccu_flags_t        flags_q
);
   function automatic logic pick(ccu_flags_t f, logic [2:0] s);
      logic b;
      case (s[1:0])
         2'd0:    b = f.neg;
         2'd1:    b = f.zer;
         2'd2:    b = f.pos;
         default: b = f.ovf;
      endcase
      return s[2] ? !b : b;
   endfunction

   // R1
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (flags_q == '0));

   // R2
   a_r2_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
      setfl_i |=> (flags_q.neg == $past(res_i[DATA_W-1])));

   // R3
   a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      setfl_i |=> (flags_q.zer == ($past(res_i) == '0)));

   // R4
   a_r4_sign_class: assert property (@(posedge clk) disable iff (!rst_n)
      setfl_i |=> ($countones({flags_q.neg, flags_q.zer, flags_q.pos}) == 1));

   a_r4_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flags_q.neg, flags_q.zer, flags_q.pos}));

   // R5
   a_r5_ovf_load: assert property (@(posedge clk) disable iff (!rst_n)
      setfl_i |=> (flags_q.ovf == $past(ovf_i)));

   // R6
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !setfl_i |=> $stable(flags_q));

   // R7 and R8: the decision always follows the register, never the next value
   a_r7_decode: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o == pick(flags_q, csel_i));

endmodule

bind ccu_flag_unit ccu_flag_unit_chk #(
   .DATA_W (DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .res_i   (res_i),
   .ovf_i   (ovf_i),
   .setfl_i (setfl_i),
   .csel_i  (csel_i),
   .taken_o (taken_o),
   .flags_q (flags_q)
);

// File: tb/ccu_flag_unit_bench.sv
`timescale 1ns/1ps
module ccu_flag_unit_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] res_i = '0;
   logic         ovf_i = 1'b0;
   logic         setfl_i = 1'b0;
   logic [2:0]   csel_i = 3'd0;
   logic         taken_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference flags (integers, behavioural)
   int m_n = 0, m_z = 0, m_p = 0, m_v = 0;

   always #2 clk = ~clk;

   ccu_flag_unit #(.DATA_W(W)) u_ccu_flag_unit (
      .clk(clk), .rst_n(rst_n), .res_i(res_i), .ovf_i(ovf_i),
      .setfl_i(setfl_i), .csel_i(csel_i), .taken_o(taken_o)
   );

   function automatic int model_taken(int s);
      int b;
      case (s % 4)
         0: b = m_n;
         1: b = m_z;
         2: b = m_p;
         default: b = m_v;
      endcase
      return (s >= 4) ? (1 - b) : b;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: csel=%0d taken actual=%0d expected=%0d (t=%0t)",
                  req, csel_i, act, exp, $time);
      end
   endtask

   // sweep all selects between edges with no update pending
   task automatic probe(string req);
      @(negedge clk);
      setfl_i = 1'b0;
      for (int c = 0; c < 8; c++) begin
         csel_i = 3'(c);
         #0.2;
         check(req, int'(taken_o), model_taken(c));
      end
   endtask

   // one instruction: check the decision before the edge, then update the model
   task automatic step(string req, logic [W-1:0] r, logic o, logic s, logic [2:0] c);
      @(negedge clk);
      res_i = r; ovf_i = o; setfl_i = s; csel_i = c;
      #0.5;
      check(req, int'(taken_o), model_taken(int'(c)));
      @(posedge clk);
      if (s) begin
         m_n = int'(r[W-1]);
         m_z = (r == '0) ? 1 : 0;
         m_p = (r != '0 && !r[W-1]) ? 1 : 0;
         m_v = int'(o);
      end
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: during reset
      res_i = 32'h8000_0000; ovf_i = 1'b1; setfl_i = 1'b1;
      repeat (3) @(posedge clk);
      probe("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      probe("R1 after release");

      // R2: negative result
      step("R2 pre", 32'h8000_0001, 1'b0, 1'b1, 3'd0);
      probe("R2");
      // R3 + R5: zero with overflow set
      step("R3 pre", 32'h0000_0000, 1'b1, 1'b1, 3'd1);
      probe("R3 R5");
      // R4 + R5: positive, overflow cleared by load
      step("R4 pre", 32'h0000_0005, 1'b0, 1'b1, 3'd3);
      probe("R4 R5");
      // R6: inputs that would change every flag, but no request
      step("R6", 32'h8000_0000, 1'b1, 1'b0, 3'd2);
      step("R6", 32'h0000_0000, 1'b1, 1'b0, 3'd5);
      probe("R6");
      // R8: branch on zero in the same cycle as an update to zero
      step("R8 same cycle", 32'h0000_0000, 1'b1, 1'b1, 3'd1);
      probe("R8 after edge");
      step("R8 same cycle inv", 32'hFFFF_FFFF, 1'b0, 1'b1, 3'd7);
      probe("R8 R7");

      // R7: random stream compared every cycle
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] r;
         case ($urandom % 4)
            0: r = '0;
            1: r = {1'b1, W'($urandom) >> 1};
            default: r = W'($urandom);
         endcase
         step("R7 random", r, 1'($urandom), 1'($urandom), 3'($urandom));
      end
      probe("R7 final");

      // R1: reset mid-run
      step("R1 pre", 32'h8000_0000, 1'b1, 1'b1, 3'd0);
      @(negedge clk);
      rst_n = 1'b0;
      m_n = 0; m_z = 0; m_p = 0; m_v = 0;
      probe("R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      probe("R1 second release");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule